// File: doc/BRIEF.md
# Dual-Bank Move Sequencer

This block sequences a move-only processor. It presents one instruction word per clock edge on a pair of address buses. Each word holds a left address, a right address and a direction bit. The words are kept in two program banks. A whole instruction cycle spans two clock edges: the first half presents the bank-0 word of a pair and the second half presents the bank-1 word of the same pair. Each bank is read during the half in which the other bank is driving the buses, so a branch needs no stall.

Branches are made by writing a pair index into a branch port, in the same way as any other move destination. A write made in the first half of a cycle redirects the following whole cycle. The second half of the current pair still executes as a shadow slot. A write whose sign bit is set is discarded, so a comparator that yields a negative value produces a fall-through.

Two program counters are kept, one for system mode and one for normal mode. The mode input chooses which counter fetches, takes branches and is read back. In normal mode a base offset is added to every branch target. A load port fills the program banks.

Top module: `movseq_top`

## Requirements
- R1: While reset is held, and until the first edge after it is released, `bus_vld`, `pcw_err`, `pc_rdata`, `bus_left`, `bus_right` and `bus_dir` are all zero.
- R2: A program word on `prog_wdata` has its direction bit at bit 2*AW, the left address at bits [2*AW-1:AW] and the right address at bits [AW-1:0]. `prog_bank` 0 selects bank 0.
- R3: The first edge after reset presents the bank-0 word of pair 0, with `bus_half`=0. `bus_half` then toggles on every edge. A second half (`bus_half`=1) presents the bank-1 word of the same pair as the first half before it.
- R4: With no accepted branch, the active pair index rises by one per whole cycle and wraps modulo 2^PA_W.
- R5: A branch write is accepted when `pcw_valid` is high on the edge that ends a first half and `pcw_data` bit DATA_W-1 is 0. The target pair index is `pcw_data[PA_W-1:0]`, and bits PA_W to DATA_W-2 are ignored.
- R6: For an accepted branch, the next edge still presents the bank-1 word of the current pair (the shadow slot). The edge after that presents the bank-0 word of the target pair.
- R7: A write made in a first half with bit DATA_W-1 set leaves the program counter and the sequence unchanged, and sets no error.
- R8: A write made on the edge that ends a second half is dropped, and sequencing continues. `pcw_err` rises on that edge and stays high until reset.
- R9: `pc_rdata` is the zero-extended program counter of the current mode, which is the index of the next pair to be fetched. After an accepted branch it shows the target from the following half onwards.
- R10: `sys_mode`=1 selects the system counter and 0 selects the normal counter. Only the selected counter advances or branches, and the other counter keeps its value.
- R11: When `sys_mode`=0, `norm_base` is added to the target modulo 2^PA_W. When `sys_mode`=1, the target is used as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one half of an instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 1 | 1 selects the system counter, 0 selects the normal counter |
| norm_base | input | PA_W | Offset added to branch targets in normal mode |
| pcw_valid | input | 1 | Branch port write strobe |
| pcw_data | input | DATA_W | Branch port write value; the MSB is the sign |
| pc_rdata | output | DATA_W | Branch port read value: the active counter |
| pcw_err | output | 1 | Sticky flag for a write made in a second half |
| prog_we | input | 1 | Program load write enable |
| prog_bank | input | 1 | Program load bank select |
| prog_addr | input | PA_W | Program load pair index |
| prog_wdata | input | 2*AW+1 | Program load word |
| bus_vld | output | 1 | The buses carry a word |
| bus_half | output | 1 | 0 for the first half, 1 for the second half |
| bus_dir | output | 1 | Direction bit of the presented word |
| bus_left | output | AW | Left address bus |
| bus_right | output | AW | Right address bus |

## Verification
The bench builds the block with PA_W=4, AW=8 and DATA_W=12. Sixteen pairs per bank make the counter wrap after only sixteen whole cycles. A 12-bit write value leaves seven ignored bits between the index field and the sign, and the bench sets those bits to check that they have no effect. A base of 5 makes a normal-mode target of 14 wrap around to pair 3, so the modular add is exercised on the same short program.

// File: rtl/movseq_pkg.sv
package movseq_pkg;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned NUM_PC   = 2;
  localparam int unsigned PC_SYS   = 1;

endpackage

// File: rtl/movseq_phase.sv
module movseq_phase
  import movseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  output half_e phase_o,
  output logic  vld_o
);

  half_e phase_q, phase_d;
  logic  vld_q, vld_d;

  always_comb begin
    phase_d = (phase_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
    vld_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= HALF_SECOND;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      vld_q   <= vld_d;
    end
  end

  assign phase_o = phase_q;
  assign vld_o   = vld_q;

endmodule

// File: rtl/movseq_bank.sv
module movseq_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 33
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_d;
  logic [WORD_W-1:0] rd_word_q;

  // storage array: no reset, loaded through the write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_d = mem_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_word_q <= '0;
    end else if (rd_en) begin
      rd_word_q <= rd_d;
    end
  end

  assign rd_q = rd_word_q;

endmodule

// File: rtl/movseq_pcunit.sv
module movseq_pcunit
  import movseq_pkg::*;
#(
  parameter int unsigned PA_W   = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cyc_start,
  input  logic              sys_mode,
  input  logic [PA_W-1:0]   norm_base,
  input  logic              pcw_valid,
  input  logic [DATA_W-1:0] pcw_data,
  output logic [PA_W-1:0]   pc_fetch,
  output logic [DATA_W-1:0] pc_rdata,
  output logic              pcw_err
);

  logic [PA_W-1:0] pc_q [NUM_PC];
  logic [PA_W-1:0] tgt;
  logic            take;
  logic            drop;
  logic            err_q, err_d;
  logic            unused_mid_bits;

  assign unused_mid_bits = ^pcw_data[DATA_W-2:PA_W];

  always_comb begin
    take = pcw_valid && !cyc_start && !pcw_data[DATA_W-1];
    drop = pcw_valid && cyc_start;
    tgt  = pcw_data[PA_W-1:0] + (sys_mode ? '0 : norm_base);
  end

  for (genvar m = 0; m < NUM_PC; m++) begin : g_pc
    logic            sel;
    logic            en;
    logic [PA_W-1:0] nxt;

    always_comb begin
      sel = (sys_mode == (m == PC_SYS));
      en  = sel && (cyc_start || take);
      nxt = cyc_start ? pc_q[m] + 1'b1 : tgt;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q[m] <= '0;
      end else if (en) begin
        pc_q[m] <= nxt;
      end
    end
  end

  always_comb begin
    err_d = err_q || drop;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign pc_fetch = sys_mode ? pc_q[PC_SYS] : pc_q[1-PC_SYS];
  assign pc_rdata = {{(DATA_W-PA_W){1'b0}}, pc_fetch};
  assign pcw_err  = err_q;

endmodule

// File: rtl/movseq_top.sv
module movseq_top
  import movseq_pkg::*;
#(
  parameter int unsigned PA_W   = 6,
  parameter int unsigned AW     = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_mode,
  input  logic [PA_W-1:0]   norm_base,
  input  logic              pcw_valid,
  input  logic [DATA_W-1:0] pcw_data,
  output logic [DATA_W-1:0] pc_rdata,
  output logic              pcw_err,
  input  logic              prog_we,
  input  logic              prog_bank,
  input  logic [PA_W-1:0]   prog_addr,
  input  logic [2*AW:0]     prog_wdata,
  output logic              bus_vld,
  output logic              bus_half,
  output logic              bus_dir,
  output logic [AW-1:0]     bus_left,
  output logic [AW-1:0]     bus_right
);

  localparam int unsigned WORD_W = 2 * AW + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  half_e           phase;
  logic            cyc_start;
  logic [PA_W-1:0] pc_fetch;
  logic [PA_W-1:0] pres_q, pres_d;
  logic [WORD_W-1:0] bank_q [NUM_BANK];
  logic [WORD_W-1:0] word;

  movseq_phase u_phase (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .phase_o (phase),
    .vld_o   (bus_vld)
  );

  assign cyc_start = (phase == HALF_SECOND);

  movseq_pcunit #(
    .PA_W   (PA_W),
    .DATA_W (DATA_W)
  ) u_pc (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .cyc_start (cyc_start),
    .sys_mode  (sys_mode),
    .norm_base (norm_base),
    .pcw_valid (pcw_valid),
    .pcw_data  (pcw_data),
    .pc_fetch  (pc_fetch),
    .pc_rdata  (pc_rdata),
    .pcw_err   (pcw_err)
  );

  // pair being presented; captured as a new whole cycle begins
  always_comb begin
    pres_d = pc_fetch;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pres_q <= '0;
    end else if (cyc_start) begin
      pres_q <= pres_d;
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic            rd_en;
    logic [PA_W-1:0] rd_addr;
    logic            wr_en;

    always_comb begin
      wr_en = prog_we && (prog_bank == b[0]);
      if (b == 0) begin
        rd_en   = cyc_start;
        rd_addr = pc_fetch;
      end else begin
        rd_en   = !cyc_start;
        rd_addr = pres_q;
      end
    end

    movseq_bank #(
      .ADDR_W (PA_W),
      .WORD_W (WORD_W)
    ) u_bank (
      .clk     (clk),
      .rst_ni  (rst_sync_n),
      .wr_en   (wr_en),
      .wr_addr (prog_addr),
      .wr_data (prog_wdata),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_q    (bank_q[b])
    );
  end

  assign word      = (phase == HALF_FIRST) ? bank_q[0] : bank_q[1];
  assign bus_half  = phase;
  assign bus_dir   = word[2*AW];
  assign bus_left  = word[2*AW-1:AW];
  assign bus_right = word[AW-1:0];

endmodule

// File: rtl/movseq_chk.sv
module movseq_chk #(
  parameter int unsigned PA_W   = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              sys_mode,
  input logic              pcw_valid,
  input logic              pcw_sign,
  input logic [DATA_W-1:0] pc_rdata,
  input logic              pcw_err,
  input logic              bus_vld,
  input logic              bus_half
);

  // R3: halves alternate on every edge once running
  a_r3_half_toggle: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_vld |=> (bus_half != $past(bus_half)));

  // R1: once valid, the buses stay valid until reset
  a_r1_vld_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_vld |=> bus_vld);

  // R4: leaving a second half advances the active counter by one
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_half |=> ($stable(sys_mode) ->
      (pc_rdata[PA_W-1:0] == PA_W'($past(pc_rdata[PA_W-1:0]) + 1'b1))));

  // R7: a negative write in a first half leaves the counter alone
  a_r7_neg_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_vld && !bus_half && pcw_valid && pcw_sign) |=>
      ($stable(sys_mode) -> $stable(pc_rdata)));

  // R8: the error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    pcw_err |=> pcw_err);

  // R8: the error flag only rises after a second-half write
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pcw_err) |-> $past(pcw_valid && bus_half));

endmodule

bind movseq_top movseq_chk #(
  .PA_W   (PA_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .sys_mode  (sys_mode),
  .pcw_valid (pcw_valid),
  .pcw_sign  (pcw_data[DATA_W-1]),
  .pc_rdata  (pc_rdata),
  .pcw_err   (pcw_err),
  .bus_vld   (bus_vld),
  .bus_half  (bus_half)
);

// File: tb/movseq_top_tb.sv
module movseq_top_tb;

  localparam int PW = 4;
  localparam int AW = 8;
  localparam int DW = 12;
  localparam int WW = 2 * AW + 1;
  localparam int NP = 1 << PW;
  localparam logic [PW-1:0] BASE = 4'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          sys_mode = 1'b1;
  logic [PW-1:0] norm_base = BASE;
  logic          pcw_valid = 1'b0;
  logic [DW-1:0] pcw_data = '0;
  logic [DW-1:0] pc_rdata;
  logic          pcw_err;
  logic          prog_we = 1'b0;
  logic          prog_bank = 1'b0;
  logic [PW-1:0] prog_addr = '0;
  logic [WW-1:0] prog_wdata = '0;
  logic          bus_vld, bus_half, bus_dir;
  logic [AW-1:0] bus_left, bus_right;

  always #5 clk = ~clk;

  movseq_top #(.PA_W(PW), .AW(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .norm_base(norm_base),
    .pcw_valid(pcw_valid), .pcw_data(pcw_data), .pc_rdata(pc_rdata),
    .pcw_err(pcw_err), .prog_we(prog_we), .prog_bank(prog_bank),
    .prog_addr(prog_addr), .prog_wdata(prog_wdata), .bus_vld(bus_vld),
    .bus_half(bus_half), .bus_dir(bus_dir), .bus_left(bus_left),
    .bus_right(bus_right)
  );

  typedef struct {
    logic [WW-1:0] word;
    logic          half;
    logic [DW-1:0] pc;
    logic          err;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_tag = "R3";

  // bench-side program image and sequencer model
  logic [WW-1:0] img [2][NP];
  logic [PW-1:0] m_pc [2];
  logic [PW-1:0] m_pres;
  logic          m_half;
  logic          m_err;

  function automatic logic [WW-1:0] mkword(input int bank, input int idx);
    logic [AW-1:0] l, r;
    logic d;
    l = AW'(idx * 13 + bank * 101 + 7);
    r = AW'((idx * 29) ^ (bank != 0 ? 8'hA5 : 8'h3C));
    d = 1'((idx ^ bank ^ (idx >> 2)) & 1);
    // R2: direction at top, then left, then right
    return {d, l, r};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({bus_dir, bus_left, bus_right} === e.word, e.tag, "word",
          32'({bus_dir, bus_left, bus_right}), 32'(e.word));
      chk(bus_half === e.half && bus_vld === 1'b1, e.tag, "half/vld",
          32'({bus_vld, bus_half}), 32'({1'b1, e.half}));
      chk(pc_rdata === e.pc, {e.tag, "_R9"}, "pc_rdata", 32'(pc_rdata), 32'(e.pc));
      chk(pcw_err === e.err, e.tag, "pcw_err", 32'(pcw_err), 32'(e.err));
    end
  end

  task automatic step(input logic v, input logic [DW-1:0] d, input logic sm);
    exp_t e;
    pcw_valid = v;
    pcw_data  = d;
    sys_mode  = sm;
    if (m_half) begin
      m_pres = m_pc[sm];
      e.word = img[0][m_pres];
      m_pc[sm] = m_pc[sm] + 1'b1;
      if (v) m_err = 1'b1;
      e.half = 1'b0;
    end else begin
      e.word = img[1][m_pres];
      if (v && !d[DW-1]) m_pc[sm] = d[PW-1:0] + (sm ? '0 : BASE);
      e.half = 1'b1;
    end
    m_half = e.half;
    e.pc   = DW'(m_pc[sm]);
    e.err  = m_err;
    e.tag  = cur_tag;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic to_first(input logic sm);
    while (m_half != 1'b0) step(1'b0, '0, sm);
  endtask

  task automatic to_second(input logic sm);
    while (m_half != 1'b1) step(1'b0, '0, sm);
  endtask

  initial begin
    m_pc[0] = '0; m_pc[1] = '0; m_pres = '0; m_half = 1'b1; m_err = 1'b0;
    #2 rst_n = 1'b0;
    @(negedge clk); #1;
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < NP; i++) begin
        img[b][i]  = mkword(b, i);
        prog_we    = 1'b1;
        prog_bank  = b[0];
        prog_addr  = PW'(i);
        prog_wdata = img[b][i];
        @(negedge clk); #1;
      end
    end
    prog_we = 1'b0;
    // R1: state while reset is held
    chk(bus_vld === 1'b0 && pcw_err === 1'b0, "R1", "vld/err in reset",
        32'({bus_vld, pcw_err}), 32'h0);
    chk(pc_rdata === '0, "R1", "pc in reset", 32'(pc_rdata), 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    // R1: after release, before the first functional edge
    chk(bus_vld === 1'b0 && {bus_dir, bus_left, bus_right} === '0, "R1",
        "outputs after release", 32'({bus_vld, bus_dir, bus_left, bus_right}), 32'h0);
    chk(pc_rdata === '0 && pcw_err === 1'b0, "R1", "pc/err after release",
        32'({pcw_err, pc_rdata}), 32'h0);

    // R2 R3 R4: plain sequencing through a wrap
    cur_tag = "R2_R3_R4";
    repeat (2 * NP + 6) step(1'b0, '0, 1'b1);

    // R5 R6: branch with shadow slot, system mode
    to_first(1'b1);
    cur_tag = "R6_shadow";
    step(1'b1, 12'd3, 1'b1);
    cur_tag = "R6_target";
    repeat (4) step(1'b0, '0, 1'b1);

    // R5: middle bits ignored (index 10)
    to_first(1'b1);
    cur_tag = "R5_midbits";
    step(1'b1, 12'h35A, 1'b1);
    repeat (4) step(1'b0, '0, 1'b1);

    // R7: negative value ignored
    to_first(1'b1);
    cur_tag = "R7_negative";
    step(1'b1, 12'h805, 1'b1);
    repeat (4) step(1'b0, '0, 1'b1);

    // R8: second-half write dropped, error sticky
    to_second(1'b1);
    cur_tag = "R8_dropped";
    step(1'b1, 12'd2, 1'b1);
    repeat (6) step(1'b0, '0, 1'b1);

    // R10: normal counter starts from its own value, system counter held
    cur_tag = "R10_normal";
    to_second(1'b1);
    repeat (6) step(1'b0, '0, 1'b0);
    cur_tag = "R10_back_sys";
    repeat (6) step(1'b0, '0, 1'b1);

    // R11: base added in normal mode, 14+5 wraps to 3
    cur_tag = "R11_base";
    to_first(1'b0);
    step(1'b1, 12'd14, 1'b0);
    repeat (4) step(1'b0, '0, 1'b0);

    // R11: negative still ignored in normal mode
    cur_tag = "R11_R7_neg_norm";
    to_first(1'b0);
    step(1'b1, 12'hFFF, 1'b0);
    repeat (3) step(1'b0, '0, 1'b0);

    @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule